// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps a processor through a multi-register load or store. The caller presents a base address, a 16-bit mask that names which registers take part, one of four address modes, a direction flag (load or store) and a writeback flag. Once the request is taken, the block issues one word access per handshake on a simple memory port. Each access carries the register index and the word address. The register file and the data path stay with the caller.

Registers always go out in ascending index order, and the lowest-numbered register always gets the lowest address. The direction mode affects only where the address window starts and where the base ends up. The start address and the final base are both computed when the request is accepted, from the number of set mask bits. After the last access, a one-cycle completion pulse presents the updated base. A writeback strobe accompanies it when the caller asked for writeback.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `req_ready` is high, and `mem_valid`, `done` and `wb_en` are low.
- R2: One access is issued for each set mask bit and for no other register. Accesses go in ascending register index, and each handshake (`mem_valid` and `mem_ready` both high) retires exactly one register.
- R3: Successive accesses step the address up by 4. The first address depends on `req_mode`, where n is the number of set mask bits:
  - 2'b10 (increment-after): base
  - 2'b11 (increment-before): base+4
  - 2'b00 (decrement-after): base-4n+4
  - 2'b01 (decrement-before): base-4n
- R4: While `done` is high, `wb_base` equals base+4n for the increment modes and base-4n for the decrement modes.
- R5: `wb_en` is high exactly when `done` is high and the request had `req_wb` set.
- R6: A request with an all-zero mask issues no access. `done` rises in the cycle after acceptance, with `wb_base` equal to the base.
- R7: `done` is a single-cycle pulse. It occurs in the cycle right after the final access handshake.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_reg_idx` and `mem_write` hold their values.
- R9: A request is taken only at a clock edge where `req_ready` and `req_valid` are both high. `req_valid` asserted during a transfer changes neither the addresses nor the indices nor the result of that transfer.
- R10: `mem_write` is the inverse of `req_load`, captured at acceptance and held for every access of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_base | input | 32 | Base address |
| req_mask | input | 16 | Register selection mask, bit i selects register i |
| req_mode | input | 2 | Address mode: bit 1 = increment, bit 0 = adjust before |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Request base writeback |
| mem_valid | output | 1 | Memory access pending |
| mem_ready | input | 1 | Memory accepts the pending access |
| mem_addr | output | 32 | Word address of the pending access |
| mem_reg_idx | output | 4 | Register index of the pending access |
| mem_write | output | 1 | Pending access is a store |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Write `wb_base` to the base register |
| wb_base | output | 32 | Updated base value |

## Verification
The bench covers all four modes with sparse, end-of-range and full masks. A design that walked downward in the decrement modes, or that counted the window from the wrong side, would show addresses reversed or shifted by one word.

Masks whose set bits are far apart catch an index picker that skips or repeats a register. An all-zero mask catches a sequencer that issues a spurious access or never finishes.

Stalled handshakes and requests raised mid-transfer target a design that advances without `mem_ready` or that restarts on a new request. A request with writeback clear checks that the strobe is gated.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  // bit 1: increment, bit 0: adjust before access
  typedef enum logic [1:0] {
    XM_DEC_AFTER  = 2'b00,
    XM_DEC_BEFORE = 2'b01,
    XM_INC_AFTER  = 2'b10,
    XM_INC_BEFORE = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_XFER = 2'b01,
    ST_FIN  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/blkx_census.sv
module blkx_census #(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CNT_W'(mask[i]);
    end
  end
endmodule

// File: rtl/blkx_pick_low.sv
module blkx_pick_low #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pending,
  output logic [NREG-1:0]  grant,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    grant = pending & (~pending + NREG'(1));
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/blkx_addr_plan.sv
module blkx_addr_plan
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  xfer_mode_e        mode,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] final_base
);
  localparam int              SH   = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_end;
  logic [ADDR_W-1:0] high_end;

  always_comb begin
    span     = ADDR_W'(count) << SH;
    low_end  = base - span;
    high_end = base + span;
    unique case (mode)
      XM_INC_AFTER:  begin start_addr = base;           final_base = high_end; end
      XM_INC_BEFORE: begin start_addr = base + STEP;    final_base = high_end; end
      XM_DEC_AFTER:  begin start_addr = low_end + STEP; final_base = low_end;  end
      default:       begin start_addr = low_end;        final_base = low_end;  end
    endcase
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [NREG-1:0]   req_mask,
  input  logic [1:0]        req_mode,
  input  logic              req_load,
  input  logic              req_wb,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  mem_reg_idx,
  output logic              mem_write,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_base
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // request-side planning
  logic [CNT_W-1:0]  req_count;
  logic [ADDR_W-1:0] plan_start;
  logic [ADDR_W-1:0] plan_final;

  blkx_census #(.NREG(NREG), .CNT_W(CNT_W)) u_census (
    .mask  (req_mask),
    .count (req_count)
  );

  blkx_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base       (req_base),
    .count      (req_count),
    .mode       (xfer_mode_e'(req_mode)),
    .start_addr (plan_start),
    .final_base (plan_final)
  );

  // state
  seq_state_e        state_q,  state_d;
  logic [NREG-1:0]   rem_q,    rem_d;
  logic [ADDR_W-1:0] addr_q,   addr_d;
  logic [ADDR_W-1:0] wbb_q,    wbb_d;
  logic              wbf_q,    wbf_d;
  logic              wr_q,     wr_d;

  logic [NREG-1:0]   pick_grant;
  logic [IDX_W-1:0]  pick_idx;
  logic [NREG-1:0]   rem_after;
  logic              take_en;
  logic              step_en;

  blkx_pick_low #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .pending (rem_q),
    .grant   (pick_grant),
    .idx     (pick_idx)
  );

  assign take_en   = (state_q == ST_IDLE) && req_valid;
  assign step_en   = (state_q == ST_XFER) && mem_ready;
  assign rem_after = rem_q & ~pick_grant;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    wbb_d   = wbb_q;
    wbf_d   = wbf_q;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_en) begin
          rem_d   = req_mask;
          addr_d  = plan_start;
          wbb_d   = plan_final;
          wbf_d   = req_wb;
          wr_d    = !req_load;
          state_d = (req_mask == '0) ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        if (step_en) begin
          rem_d  = rem_after;
          addr_d = addr_q + STEP;
          if (rem_after == '0) state_d = ST_FIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wbb_q   <= '0;
      wbf_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_en || step_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (take_en) begin
        wbb_q <= wbb_d;
        wbf_q <= wbf_d;
        wr_q  <= wr_d;
      end
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_valid   = (state_q == ST_XFER);
  assign mem_addr    = addr_q;
  assign mem_reg_idx = pick_idx;
  assign mem_write   = wr_q;
  assign done        = (state_q == ST_FIN);
  assign wb_en       = done && wbf_q;
  assign wb_base     = wbb_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_reg_idx) && $stable(mem_write)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> (!mem_valid && !done));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + STEP)));

  // R2
  idx_pending_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_valid |-> rem_q[mem_reg_idx]);

  // R5
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wb_en |-> done);
endmodule

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_base;
  logic [15:0] req_mask;
  logic [1:0]  req_mode;
  logic        req_load;
  logic        req_wb;
  logic        mem_valid;
  logic        mem_ready;
  logic [31:0] mem_addr;
  logic [3:0]  mem_reg_idx;
  logic        mem_write;
  logic        done;
  logic        wb_en;
  logic [31:0] wb_base;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  blk_xfer_seq dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_base, .req_mask, .req_mode,
    .req_load, .req_wb, .mem_valid, .mem_ready, .mem_addr, .mem_reg_idx,
    .mem_write, .done, .wb_en, .wb_base
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask,
                          input logic [1:0] mode, input bit load, input bit wb,
                          input bit stall, input bit noise);
    logic [31:0] exp_addr[16];
    logic [3:0]  exp_idx[16];
    logic [31:0] start, fin, held_addr;
    logic [3:0]  held_idx;
    bit          was_stalled = 0;
    bit          seen_done = 0;
    int          n = 0;
    int          k = 0;
    int          cyc = 0;
    for (int i = 0; i < 16; i++) if (mask[i]) n++;
    case (mode)
      2'b10: begin start = base;                         fin = base + 32'(4*n); end
      2'b11: begin start = base + 32'd4;                 fin = base + 32'(4*n); end
      2'b00: begin start = base - 32'(4*n) + 32'd4;      fin = base - 32'(4*n); end
      default: begin start = base - 32'(4*n);            fin = base - 32'(4*n); end
    endcase
    begin
      int j = 0;
      for (int i = 0; i < 16; i++) begin
        if (mask[i]) begin
          exp_idx[j]  = 4'(i);
          exp_addr[j] = start + 32'(4*j);
          j++;
        end
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", {31'd0, req_ready}, 32'd1);
    req_base = base; req_mask = mask; req_mode = mode;
    req_load = load; req_wb = wb; req_valid = 1'b1;
    while (!seen_done && cyc < 200) begin
      @(negedge clk);
      req_valid = noise;
      if (noise) begin req_mask = 16'h00FF ^ mask; req_base = 32'hDEAD_0000; req_mode = ~mode; end
      mem_ready = stall ? cyc[0] : 1'b1;
      #1;
      if (was_stalled) begin
        chk(mem_addr == held_addr && mem_reg_idx == held_idx, "R8", "stall hold addr",
            mem_addr, held_addr);
      end
      was_stalled = 0;
      if (mem_valid) begin
        chk(k < n, "R2", "extra access", 32'(k), 32'(n));
        chk(mem_write == !load, "R10", "write flag", {31'd0, mem_write}, {31'd0, !load});
        if (k < n) begin
          chk(mem_reg_idx == exp_idx[k], "R2", "register index", {28'd0, mem_reg_idx},
              {28'd0, exp_idx[k]});
          chk(mem_addr == exp_addr[k], "R3", "access address", mem_addr, exp_addr[k]);
        end
        if (mem_ready) k++;
        else begin was_stalled = 1; held_addr = mem_addr; held_idx = mem_reg_idx; end
      end
      if (done) begin
        seen_done = 1;
        req_valid = 1'b0;
        chk(k == n, "R7", "done after last access", 32'(k), 32'(n));
        chk(wb_base == fin, (n == 0) ? "R6" : "R4", "final base", wb_base, fin);
        chk(wb_en == wb, "R5", "writeback strobe", {31'd0, wb_en}, {31'd0, wb});
        if (n == 0) chk(cyc == 0, "R6", "empty mask latency", 32'(cyc), 32'd0);
      end
      cyc++;
    end
    chk(seen_done, "R7", "done seen", {31'd0, seen_done}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    mem_ready = 1'b0;
    #1;
    chk(done == 1'b0, "R7", "done single cycle", {31'd0, done}, 32'd0);
    chk(req_ready == 1'b1, "R9", "idle after done", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic test_reset();
    req_valid = 0; req_base = 0; req_mask = 0; req_mode = 0;
    req_load = 0; req_wb = 0; mem_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "reset ready", {31'd0, req_ready}, 32'd1);
    chk(mem_valid == 1'b0, "R1", "reset mem_valid", {31'd0, mem_valid}, 32'd0);
    chk(done == 1'b0 && wb_en == 1'b0, "R1", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    // R3 increment-after, registers 1..3
    run_xfer(32'h0008_0010, 16'h000E, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3 increment-before, store, registers 0 and 15
    run_xfer(32'h0000_1000, 16'h8001, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3 decrement-after, registers 4..7
    run_xfer(32'h0000_2000, 16'h00F0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8 R5 decrement-before with stalls, no writeback
    run_xfer(32'h0000_2000, 16'h0421, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6 empty mask
    run_xfer(32'h0000_3000, 16'h0000, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9 full mask with requests raised during the transfer
    run_xfer(32'h0001_0000, 16'hFFFF, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1);
    // R10 load after store with stalls
    run_xfer(32'h0000_4000, 16'h1248, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule